// File: doc/BRIEF.md
# Prescaled Dual-Output PWM Timer Channel

This block is a single timer channel that drives two pulse-width-modulated pins from one shared 16-bit up-counter. The counter advances once per prescaled tick. A 2-bit code selects the divide ratio, which is always a power of four. The counter wraps to zero when it reaches the period value of whichever output pair is chosen as the clear source. Each output owns a period register and a duty register. With normal polarity an output is high while the counter is below its duty value. When the duty value is not below the output's own period value, the output stays high for the whole cycle.

Software configures the channel through a small write port. Address 0 holds the control word: bits [1:0] are the prescale code and bit 2 selects the clear source (0 = first pair, 1 = second pair). Address 1 holds the output enables (bit 0 for the first pin, bit 1 for the second). Addresses 2 and 3 are the first pair's period and duty. Addresses 4 and 5 are the second pair's period and duty. The `run` level starts and stops the counter. The control word is guarded: it can only change while the counter is stopped. Compare values are double-buffered, so they take effect at the next counter clear. A disabled pin has its output-enable deasserted, and its data line is held low so that the pad floats.

Top module: `ptm_channel`

## Requirements
- R1: After reset the counter is zero and stopped. Both `pwm_oe` bits are 0, both `pwm_o` bits are 0, `cfg_err` is 0, and every register reads as zero.
- R2: While `run` is high, the counter advances once every 4^p clock cycles, where p is control bits [1:0] (ratios 1, 4, 16, 64).
- R3: The counter counts 0, 1, ... up to P and then returns to 0, which gives a cycle of (P+1)·4^p clocks. P is the period register of the pair selected by control bit 2: the address 2 register when the bit is 0, and the address 4 register when it is 1.
- R4: An enabled output is high while the counter is below its duty register (address 3 for the first output, 5 for the second) and low otherwise.
- R5: When an output's duty value is greater than or equal to its own period value, that output stays high for the entire cycle.
- R6: A write to address 0 while `run` is high leaves prescale and clear source unchanged, and `cfg_err` is high for exactly the cycle after that write.
- R7: A write to address 0 while `run` is low takes effect before the counter next starts.
- R8: A compare write made while running first affects the output at the next counter clear. A compare write made while stopped is in force one cycle later.
- R9: Address 1 bit k drives `pwm_oe[k]`. While bit k is 0, `pwm_o[k]` is 0.
- R10: Both outputs follow the same counter and therefore the same prescale setting.
- R11: While `run` is low the counter holds its value, so the outputs stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter runs while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_o | output | 2 | PWM pin data, one per output |
| pwm_oe | output | 2 | Pin output-enable, one per output |
| cfg_err | output | 1 | One-cycle flag for a refused control write |

## Verification
The hardest case to reach is a compare write that lands mid-period while the counter runs. Its effect must be deferred to an exact clear edge. The bench starts the counter at a known edge and counts edges itself. It writes a new duty a few ticks before the wrap and predicts the waveform with the old value up to that wrap and the new value after it. A refused control write is issued in the middle of a slow-prescale run, while the scoreboard keeps comparing the waveform against the old ratio.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_OUTEN = 3'd1,
    A_PER0  = 3'd2,
    A_DUTY0 = 3'd3,
    A_PER1  = 3'd4,
    A_DUTY1 = 3'd5
  } ptm_addr_e;

  typedef struct packed {
    logic       clr_sel;
    logic [1:0] psc;
  } ptm_ctrl_t;

  // last prescaler phase for a given code: 4^code - 1
  function automatic logic [5:0] psc_last(input logic [1:0] code);
    logic [6:0] ratio;
    ratio = 7'd1 << (2 * code);
    return 6'(ratio - 7'd1);
  endfunction

  // pin level with normal polarity and duty clamp
  function automatic logic pwm_level(input logic [15:0] cnt,
                                     input logic [15:0] duty,
                                     input logic [15:0] per);
    return (duty >= per) || (cnt < duty);
  endfunction

endpackage

// File: rtl/ptm_prescaler.sv
module ptm_prescaler #(
  parameter int unsigned PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int unsigned DIV_W = 2 * ((1 << PSC_W) - 1);

  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] last;

  always_comb begin
    last = '0;
    for (int i = 0; i < (1 << PSC_W); i++) begin
      if (code == PSC_W'(i)) last = DIV_W'((64'd1 << (2 * i)) - 64'd1);
    end
  end

  assign tick = run && (phase == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (!run)   phase <= '0;
    else if (tick)   phase <= '0;
    else             phase <= phase + 1'b1;
  end

  AST_NO_BACK_TO_BACK_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != '0 && run) |=> !tick); // R2

endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  assign wrap = tick && (count == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (wrap)  count <= '0;
    else if (tick)  count <= count + 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0)); // R3

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count)); // R11

endmodule

// File: rtl/ptm_output.sv
module ptm_output #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic             wr_per,
  input  logic             wr_duty,
  input  logic [CNT_W-1:0] wdata,
  input  logic             en,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] per_act,
  output logic             pin,
  output logic             pin_oe
);
  logic [CNT_W-1:0] per_buf, duty_buf, duty_act;
  logic             load;
  logic             level;

  assign load = !run || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf  <= '0;
      duty_buf <= '0;
    end else begin
      if (wr_per)  per_buf  <= wdata;
      if (wr_duty) duty_buf <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act  <= '0;
      duty_act <= '0;
    end else if (load) begin
      per_act  <= per_buf;
      duty_act <= duty_buf;
    end
  end

  assign level  = ptm_pkg::pwm_level(count, duty_act, per_act);
  assign pin    = en & level;
  assign pin_oe = en;

  AST_DUTY_FROZEN_MID_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(duty_act)); // R8

  AST_CLAMPED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && duty_act >= per_act) |-> pin); // R5

endmodule

// File: rtl/ptm_channel.sv
module ptm_channel #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 2,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [1:0]        pwm_o,
  output logic [1:0]        pwm_oe,
  output logic              cfg_err
);
  import ptm_pkg::*;

  localparam int unsigned NOUT = 2;

  logic [PSC_W-1:0] psc_q;
  logic             clr_sel_q;
  logic [NOUT-1:0]  oe_q;
  logic             err_q;
  logic             ctrl_wr;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] per_sel;
  logic [CNT_W-1:0] per_act [NOUT];

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q     <= '0;
      clr_sel_q <= 1'b0;
      oe_q      <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= ctrl_wr && run;
      if (ctrl_wr && !run) begin
        psc_q     <= wr_data[PSC_W-1:0];
        clr_sel_q <= wr_data[PSC_W];
      end
      if (wr_en && wr_addr == ADDR_W'(A_OUTEN)) oe_q <= wr_data[NOUT-1:0];
    end
  end

  assign cfg_err = err_q;

  ptm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .code(psc_q), .tick(tick)
  );

  assign per_sel = clr_sel_q ? per_act[1] : per_act[0];

  ptm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(per_sel),
    .count(count), .wrap(wrap)
  );

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    localparam logic [ADDR_W-1:0] PER_ADDR  = ADDR_W'(2 + 2 * k);
    localparam logic [ADDR_W-1:0] DUTY_ADDR = ADDR_W'(3 + 2 * k);
    logic wr_per, wr_duty;
    assign wr_per  = wr_en && (wr_addr == PER_ADDR);
    assign wr_duty = wr_en && (wr_addr == DUTY_ADDR);

    ptm_output #(.CNT_W(CNT_W)) u_out (
      .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap),
      .wr_per(wr_per), .wr_duty(wr_duty), .wdata(wr_data),
      .en(oe_q[k]), .count(count), .per_act(per_act[k]),
      .pin(pwm_o[k]), .pin_oe(pwm_oe[k])
    );
  end

  AST_CTRL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && run) |=> (cfg_err && $stable(psc_q) && $stable(clr_sel_q))); // R6

  AST_ERR_ONLY_ON_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && run) |=> !cfg_err); // R6

endmodule

// File: tb/tb_ptm_channel.sv
module tb_ptm_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  pwm_o, pwm_oe;
  logic        cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    bit    e0;
    bit    e1;
    string t0;
    string t1;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  ptm_channel dut (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o), .pwm_oe(pwm_oe), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  // monitor: one scoreboard item per clock, sampled on the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      check(it.t0, int'(pwm_o[0]), int'(it.e0));
      check(it.t1, int'(pwm_o[1]), int'(it.e1));
    end
  end

  function automatic bit model(int n, int ratio, int psel, int duty, int pown);
    if (duty >= pown) return 1'b1;
    return ((n / ratio) % (psel + 1)) < duty;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    run = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic setup(input int ctrl, input int a, input int b, input int c,
                       input int d, input int oe);
    wr(3'd0, 16'(ctrl));
    wr(3'd2, 16'(a));
    wr(3'd3, 16'(b));
    wr(3'd4, 16'(c));
    wr(3'd5, 16'(d));
    wr(3'd1, 16'(oe));
    repeat (2) @(posedge clk);
  endtask

  // driver: start the counter and queue the predicted waveform
  task automatic start_and_push(input int ncyc, input int ratio, input bit src_c,
                                input int a, input int b, input int c, input int d,
                                input int split, input int b_new,
                                input string t0a, input string t0b, input string t1);
    int psel;
    psel = src_c ? c : a;
    @(posedge clk); #1;
    run = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      exp_t it;
      int   bb;
      bb = (split >= 0 && n >= split) ? b_new : b;
      it.e0 = model(n, ratio, psel, bb, a);
      it.e1 = model(n, ratio, psel, d, c);
      it.t0 = (split >= 0 && n >= split) ? t0b : t0a;
      it.t1 = t1;
      sb_q.push_back(it);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1", int'(pwm_oe), 0);
    check("R1", int'(pwm_o), 0);
    check("R1", int'(cfg_err), 0);

    // Test 1: ratio 1, clear on first pair, mid-run duty change (R4, R8)
    setup(32'h0, 9, 3, 20, 5, 3);
    @(negedge clk);
    check("R9", int'(pwm_oe), 3);
    start_and_push(60, 1, 1'b0, 9, 3, 20, 5, 20, 7, "R4", "R8", "R4");
    repeat (12) @(posedge clk);
    #1 wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'd7;
    @(posedge clk); #1 wr_en = 1'b0;
    wait (sb_q.size() == 0);
    // R11: stop and confirm the pins freeze
    @(posedge clk); #1 run = 1'b0;
    @(negedge clk);
    begin
      logic [1:0] held;
      held = pwm_o;
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        check("R11", int'(pwm_o), int'(held));
      end
    end
    // R9: disable second output
    wr(3'd1, 16'd1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R9", int'(pwm_oe), 1);
      check("R9", int'(pwm_o[1]), 0);
    end
    run = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R9", int'(pwm_o[1]), 0);
    end
    run = 1'b0;

    // Test 2: ratio 4, clamp on second output, refused control write (R6, R7)
    do_reset();
    setup(32'h1, 4, 2, 4, 9, 3);
    start_and_push(120, 4, 1'b0, 4, 2, 4, 9, 32, 2, "R7", "R6", "R5");
    repeat (30) @(posedge clk);
    #1 wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h4;
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk);
    check("R6", int'(cfg_err), 1);
    @(negedge clk);
    check("R6", int'(cfg_err), 0);
    wait (sb_q.size() == 0);

    // Test 3: ratio 16, clear on second pair (R3, R5)
    do_reset();
    setup(32'h6, 50, 1, 3, 3, 3);
    start_and_push(200, 16, 1'b1, 50, 1, 3, 3, -1, 0, "R3", "R3", "R5");
    wait (sb_q.size() == 0);

    // Test 4: ratio 64, both outputs on shared count (R2, R10)
    do_reset();
    setup(32'h3, 2, 1, 100, 2, 3);
    start_and_push(420, 64, 1'b0, 2, 1, 100, 2, -1, 0, "R2", "R2", "R10");
    wait (sb_q.size() == 0);

    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  end

endmodule